// File: doc/BRIEF.md
# Mixture-of-Gaussians Pixel Model Updater

This block is the arithmetic core of a streaming background-subtraction engine. With each valid input it receives one 8-bit grayscale pixel and that pixel's stored background model: three Gaussians, each holding a mean, a variance, a weight and a match counter. It returns the model updated for the new pixel, together with a one-bit tag that says whether the pixel belongs to the foreground. The frame store that holds the models lives outside the block. So do the video timing logic and any mask cleanup. The caller streams each model in and writes the returned model back.

All arithmetic is fixed point. Three functions come from ROMs that are filled at elaboration:
- the inverse standard deviation used for ranking,
- the learning-rate shift exponent,
- the reseed weight.

Every learning-rate product is an arithmetic right shift. The pipeline has two register stages. A parameter adds further stages when timing needs them. The result for a pixel always comes out aligned with that pixel's valid flag.

Top module: `mog_pixel_model`

## Requirements
- R1: Each accepted input (`in_valid`=1) produces exactly one `out_valid` pulse. The pulse comes 2+EXTRA_LAT clock edges later, and results leave in input order. With no accepted input, `out_valid` stays low.
- R2: The model is 108 bits. Gaussian k occupies bits [36k+35:36k]. Within it, mean is [7:0] (integer), variance is [19:8] (integer), weight is [29:20] (fraction, 1023 ≈ 1.0) and counter is [35:30]. Fitness of Gaussian k is weight × inv(variance), where inv(0)=255 and inv(v)=min(255, floor(256/sqrt(v))). Gaussians are ranked by descending fitness; on equal fitness, the lower index ranks first.
- R3: Gaussian k matches when 4·(pixel−mean)² < 25·variance. When several match, the one with the best rank is the selected one.
- R4: For the selected Gaussian:
  - the shift nk is read from a table indexed by weight[9:4]. It is 1 for index 0. Otherwise it is max(1, NW−5+floor(log2(index))).
  - mean += floor((pixel−mean)/2^nk).
  - variance += floor(((pixel−mean)² − variance)/2^nk). The result is clamped to [VAR_MIN, 4095].
- R5: For the selected Gaussian, the new weight is min(1023, w − floor(w/2^NW) + 2^(10−NW)). Its counter increments and saturates at 63.
- R6: A Gaussian that is neither selected nor reseeded keeps its mean, variance and counter. Its weight becomes w − floor(w/2^NW).
- R7: When no Gaussian matches, the last-ranked Gaussian is reseeded. Its mean becomes the pixel, its variance becomes VAR_INIT and its counter becomes 1. The other two decay as in R6.
- R8: The reseed weight is floor(1023/(S+1)). S is the sum of the other two Gaussians' counters, saturated at 63.
- R9: `out_fg` is 0 (background) only when the pixel matches some Gaussian k for which the weights of all better-ranked Gaussians sum to at most THRESH. Otherwise `out_fg` is 1.
- R10: While `rst` is high and right after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel and model are valid |
| in_pixel | input | 8 | Grayscale pixel value |
| in_model | input | 108 | Stored three-Gaussian model for this pixel |
| out_valid | output | 1 | Output model and tag are valid |
| out_model | output | 108 | Updated model |
| out_fg | output | 1 | 1 = foreground, 0 = background |

## Verification
The hardest cases to produce are ties and limits:
- ties in fitness, where rank order falls back on the index;
- a pixel sitting exactly on the match threshold;
- a reseed whose counter sum saturates;
- updates that hit the weight or variance limits.

Uniformly random models and pixels almost never create these. The bench therefore builds such models directly through the model input, including identical Gaussians and a squared distance equal to 6.25 times the variance. The random traffic is also biased: pixels are drawn near one of the stored means, so that multiple matches and rank-dependent selection come up often.

// File: rtl/mog_pkg.sv
package mog_pkg;
  localparam int NG     = 3;
  localparam int MEAN_W = 8;
  localparam int VAR_W  = 12;
  localparam int WT_W   = 10;
  localparam int CNT_W  = 6;
  localparam int INV_W  = 8;
  localparam int NK_W   = 4;
  localparam int NKA_W  = 6;
  localparam int G_W    = MEAN_W + VAR_W + WT_W + CNT_W;
  localparam int MODEL_W = NG * G_W;

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [WT_W-1:0]   wt;
    logic [VAR_W-1:0]  vr;
    logic [MEAN_W-1:0] mu;
  } gauss_t;

  typedef enum logic [1:0] {ROM_INVSQRT, ROM_SHIFT, ROM_RESEED} rom_kind_e;
endpackage

// File: rtl/mog_rom.sv
module mog_rom import mog_pkg::*; #(
  parameter rom_kind_e KIND = ROM_INVSQRT,
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int DEPTH = 1 << AW;
  localparam int CAP   = (1 << DW) - 1;

  logic [DW-1:0] mem [DEPTH];

  // table contents computed at elaboration; registered read maps to block RAM
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      int t;
      t = 0;
      case (KIND)
        ROM_INVSQRT: t = (i == 0) ? CAP : $rtoi(real'(CAP + 1) / $sqrt(real'(i)));
        ROM_SHIFT: begin
          t = 1;
          for (int b = 0; b < AW; b++)
            if (((i >> b) & 1) != 0) t = NW - (AW - 1) + b;
          if (t < 1) t = 1;
        end
        default: t = CAP / (i + 1);
      endcase
      if (t > CAP) t = CAP;
      mem[i] = DW'(t);
    end
  end

  always_ff @(posedge clk) data <= mem[addr];
endmodule

// File: rtl/mog_classify.sv
module mog_classify import mog_pkg::*; #(
  parameter int THRESH = 717
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        act,
  input  logic [MEAN_W-1:0]           pix,
  input  logic [NG-1:0][MEAN_W-1:0]   mu,
  input  logic [NG-1:0][VAR_W-1:0]    vr,
  input  logic [NG-1:0][WT_W-1:0]     wt,
  input  logic [NG-1:0][INV_W-1:0]    inv,
  output logic [NG-1:0]               sel,
  output logic [NG-1:0]               low,
  output logic                        fg
);
  localparam int FIT_W = WT_W + INV_W;
  localparam int RK_W  = $clog2(NG);
  localparam int SUM_W = WT_W + RK_W + 1;
  localparam int CMP_W = 2 * MEAN_W + 3;

  logic [NG-1:0][FIT_W-1:0] fit;
  logic [NG-1:0][RK_W-1:0]  rank;
  logic [NG-1:0]            hit;
  logic [NG-1:0]            incl;
  logic [MEAN_W-1:0]        ad;
  logic [CMP_W-1:0]         sq;
  logic [SUM_W-1:0]         pre;

  always_comb begin
    for (int k = 0; k < NG; k++) begin
      fit[k] = FIT_W'(wt[k]) * FIT_W'(inv[k]);
      ad = (pix >= mu[k]) ? pix - mu[k] : mu[k] - pix;
      sq = CMP_W'(ad) * CMP_W'(ad);
      hit[k] = (sq << 2) < (CMP_W'(25) * CMP_W'(vr[k]));
    end
    for (int k = 0; k < NG; k++) begin
      rank[k] = '0;
      for (int j = 0; j < NG; j++)
        if (j != k && (fit[j] > fit[k] || (fit[j] == fit[k] && j < k)))
          rank[k] = rank[k] + 1'b1;
    end
    for (int k = 0; k < NG; k++) begin
      pre = '0;
      for (int j = 0; j < NG; j++)
        if (rank[j] < rank[k]) pre = pre + SUM_W'(wt[j]);
      incl[k] = (pre <= SUM_W'(THRESH));
      low[k]  = (rank[k] == RK_W'(NG - 1));
      sel[k]  = hit[k];
      for (int j = 0; j < NG; j++)
        if (hit[j] && rank[j] < rank[k]) sel[k] = 1'b0;
    end
    fg = ~|(hit & incl);
  end

  assert_single_pick_R3: assert property (@(posedge clk) disable iff (rst)
    act |-> $onehot0(sel));
  assert_one_last_rank_R2: assert property (@(posedge clk) disable iff (rst)
    act |-> $countones(low) == 1);
  assert_bg_has_match_R9: assert property (@(posedge clk) disable iff (rst)
    (act && !fg) |-> (sel != '0));
endmodule

// File: rtl/mog_update.sv
module mog_update import mog_pkg::*; #(
  parameter int NW = 5,
  parameter int VAR_INIT = 225,
  parameter int VAR_MIN = 4
) (
  input  logic [MEAN_W-1:0] pix,
  input  gauss_t            g,
  input  logic [NK_W-1:0]   nk,
  input  logic [WT_W-1:0]   seed_w,
  input  logic              sel,
  input  logic              reseed,
  output gauss_t            q
);
  localparam int D_W  = MEAN_W + 2;
  localparam int E_W  = 2 * MEAN_W + 3;
  localparam int WMAX = (1 << WT_W) - 1;
  localparam int VMAX = (1 << VAR_W) - 1;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam logic [WT_W:0] W_GAIN = (WT_W + 1)'(1 << (WT_W - NW));

  logic signed [D_W-1:0] d;
  logic [MEAN_W-1:0]     ad;
  logic signed [E_W-1:0] e, vnew;
  logic [WT_W-1:0]       wdec;
  logic [WT_W:0]         winc;
  gauss_t                upd;

  always_comb begin
    d    = $signed({2'b00, pix}) - $signed({2'b00, g.mu});
    ad   = (pix >= g.mu) ? pix - g.mu : g.mu - pix;
    e    = $signed(E_W'(ad) * E_W'(ad)) - $signed(E_W'(g.vr));
    vnew = $signed(E_W'(g.vr)) + (e >>> nk);
    wdec = g.wt - (g.wt >> NW);
    winc = {1'b0, wdec} + W_GAIN;

    upd.mu = MEAN_W'($signed({2'b00, g.mu}) + (d >>> nk));
    if (vnew > $signed(E_W'(VMAX)))         upd.vr = VAR_W'(VMAX);
    else if (vnew < $signed(E_W'(VAR_MIN))) upd.vr = VAR_W'(VAR_MIN);
    else                                    upd.vr = vnew[VAR_W-1:0];
    upd.wt  = (winc > (WT_W + 1)'(WMAX)) ? WT_W'(WMAX) : winc[WT_W-1:0];
    upd.cnt = (g.cnt == CNT_W'(CMAX)) ? g.cnt : g.cnt + 1'b1;

    if (reseed)   q = '{cnt: CNT_W'(1), wt: seed_w, vr: VAR_W'(VAR_INIT), mu: pix};
    else if (sel) q = upd;
    else          q = '{cnt: g.cnt, wt: wdec, vr: g.vr, mu: g.mu};
  end
endmodule

// File: rtl/mog_pixel_model.sv
module mog_pixel_model import mog_pkg::*; #(
  parameter int NW        = 5,
  parameter int THRESH    = 717,
  parameter int VAR_INIT  = 225,
  parameter int VAR_MIN   = 4,
  parameter int EXTRA_LAT = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [MEAN_W-1:0]  in_pixel,
  input  logic [MODEL_W-1:0] in_model,
  output logic               out_valid,
  output logic [MODEL_W-1:0] out_model,
  output logic               out_fg
);
  localparam int OS_W = CNT_W + 2;
  localparam int CMAX = (1 << CNT_W) - 1;

  gauss_t [NG-1:0] in_g, s1_g, upd;
  logic            s1_v;
  logic [MEAN_W-1:0] s1_pix;
  logic [NG-1:0][INV_W-1:0]  s1_inv;
  logic [NG-1:0][NK_W-1:0]   s1_nk;
  logic [NG-1:0][WT_W-1:0]   s1_seed;
  logic [NG-1:0][CNT_W-1:0]  seed_addr;
  logic [OS_W-1:0]           osum;
  logic [NG-1:0][MEAN_W-1:0] mu_a;
  logic [NG-1:0][VAR_W-1:0]  vr_a;
  logic [NG-1:0][WT_W-1:0]   wt_a;
  logic [NG-1:0]             sel, low, reseed;
  logic                      fg;

  assign in_g = in_model;

  // stage 1: register inputs alongside the three ROM reads per Gaussian
  always_comb begin
    for (int k = 0; k < NG; k++) begin
      osum = '0;
      for (int j = 0; j < NG; j++)
        if (j != k) osum = osum + OS_W'(in_g[j].cnt);
      seed_addr[k] = (osum > OS_W'(CMAX)) ? CNT_W'(CMAX) : osum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    s1_pix <= in_pixel;
    s1_g   <= in_g;
  end

  // stage 2: classification and per-Gaussian update
  always_comb begin
    for (int k = 0; k < NG; k++) begin
      mu_a[k] = s1_g[k].mu;
      vr_a[k] = s1_g[k].vr;
      wt_a[k] = s1_g[k].wt;
    end
  end

  mog_classify #(.THRESH(THRESH)) u_class (
    .clk(clk), .rst(rst), .act(s1_v), .pix(s1_pix),
    .mu(mu_a), .vr(vr_a), .wt(wt_a), .inv(s1_inv),
    .sel(sel), .low(low), .fg(fg));

  assign reseed = low & {NG{~|sel}};

  for (genvar k = 0; k < NG; k++) begin : g_gauss
    mog_rom #(.KIND(ROM_INVSQRT), .AW(VAR_W), .DW(INV_W), .NW(NW)) u_inv (
      .clk(clk), .addr(in_g[k].vr), .data(s1_inv[k]));
    mog_rom #(.KIND(ROM_SHIFT), .AW(NKA_W), .DW(NK_W), .NW(NW)) u_nk (
      .clk(clk), .addr(in_g[k].wt[WT_W-1 -: NKA_W]), .data(s1_nk[k]));
    mog_rom #(.KIND(ROM_RESEED), .AW(CNT_W), .DW(WT_W), .NW(NW)) u_seed (
      .clk(clk), .addr(seed_addr[k]), .data(s1_seed[k]));

    mog_update #(.NW(NW), .VAR_INIT(VAR_INIT), .VAR_MIN(VAR_MIN)) u_upd (
      .pix(s1_pix), .g(s1_g[k]), .nk(s1_nk[k]), .seed_w(s1_seed[k]),
      .sel(sel[k]), .reseed(reseed[k]), .q(upd[k]));

    assert_idle_keeps_R6: assert property (@(posedge clk) disable iff (rst)
      (s1_v && !sel[k] && !reseed[k]) |->
      (upd[k].mu == s1_g[k].mu && upd[k].vr == s1_g[k].vr && upd[k].wt <= s1_g[k].wt));
  end

  assert_one_reseed_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_v && sel == '0) |-> $countones(reseed) == 1);

  // output registers plus optional extra stages
  logic [EXTRA_LAT:0]              dv;
  logic [EXTRA_LAT:0][MODEL_W-1:0] dm;
  logic [EXTRA_LAT:0]              df;

  always_ff @(posedge clk) begin
    if (rst) dv <= '0;
    else begin
      for (int s = EXTRA_LAT; s > 0; s--) dv[s] <= dv[s-1];
      dv[0] <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = EXTRA_LAT; s > 0; s--) begin
      dm[s] <= dm[s-1];
      df[s] <= df[s-1];
    end
    dm[0] <= upd;
    df[0] <= fg;
  end

  assign out_valid = dv[EXTRA_LAT];
  assign out_model = dm[EXTRA_LAT];
  assign out_fg    = df[EXTRA_LAT];
endmodule

// File: tb/mog_pixel_model_tb_top.sv
module mog_pixel_model_tb_top;
  localparam int NW = 5, TH = 717, VINIT = 225, VMIN = 4, LAT = 2;
  localparam int NRAND = 1500;
  localparam int N = NRAND + 20;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [7:0] in_pixel = '0;
  logic [107:0] in_model = '0;
  logic out_valid, out_fg;
  logic [107:0] out_model;

  always #5 clk = ~clk;

  mog_pixel_model dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pixel(in_pixel), .in_model(in_model),
    .out_valid(out_valid), .out_model(out_model), .out_fg(out_fg));

  int checks = 0, errors = 0, sent = 0, got = 0;
  longint cyc = 0;
  logic [107:0] exp_m [N];
  logic exp_f [N];
  longint t_in [N];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int invs(input int v);
    int t;
    t = (v == 0) ? 255 : $rtoi(256.0 / $sqrt(real'(v)));
    return (t > 255) ? 255 : t;
  endfunction

  function automatic int nkf(input int idx);
    int t;
    t = 1;
    for (int b = 0; b < 6; b++) if (((idx >> b) & 1) != 0) t = NW - 5 + b;
    return (t < 1) ? 1 : t;
  endfunction

  function automatic logic [35:0] gs(input int mu, input int vr, input int wt, input int cn);
    return {6'(cn), 10'(wt), 12'(vr), 8'(mu)};
  endfunction

  function automatic void ref_px(input int p, input logic [107:0] m,
                                 output logic [107:0] q, output logic fg);
    int mu[3], vr[3], wt[3], cn[3], fit[3], rk[3], adv[3];
    bit hit[3];
    int sel, pre, s, d, e, v, w, nk, nmu, nvr, nwt, ncn;
    for (int k = 0; k < 3; k++) begin
      mu[k] = int'(m[36*k +: 8]);
      vr[k] = int'(m[36*k+8 +: 12]);
      wt[k] = int'(m[36*k+20 +: 10]);
      cn[k] = int'(m[36*k+30 +: 6]);
      fit[k] = wt[k] * invs(vr[k]);
      adv[k] = (p > mu[k]) ? p - mu[k] : mu[k] - p;
      hit[k] = (4 * adv[k] * adv[k]) < (25 * vr[k]);
    end
    for (int k = 0; k < 3; k++) begin
      rk[k] = 0;
      for (int j = 0; j < 3; j++)
        if (j != k && (fit[j] > fit[k] || (fit[j] == fit[k] && j < k))) rk[k]++;
    end
    fg = 1'b1;
    for (int k = 0; k < 3; k++) begin
      pre = 0;
      for (int j = 0; j < 3; j++) if (rk[j] < rk[k]) pre += wt[j];
      if (pre <= TH && hit[k]) fg = 1'b0;
    end
    sel = -1;
    for (int k = 0; k < 3; k++) if (hit[k] && (sel < 0 || rk[k] < rk[sel])) sel = k;
    for (int k = 0; k < 3; k++) begin
      nmu = mu[k]; nvr = vr[k]; ncn = cn[k]; nwt = wt[k] - (wt[k] >> NW);
      if (sel < 0 && rk[k] == 2) begin
        s = 0;
        for (int j = 0; j < 3; j++) if (j != k) s += cn[j];
        if (s > 63) s = 63;
        nmu = p; nvr = VINIT; nwt = 1023 / (s + 1); ncn = 1;
      end else if (k == sel) begin
        nk = nkf(wt[k] >> 4);
        d = p - mu[k];
        nmu = mu[k] + (d >>> nk);
        e = adv[k] * adv[k] - vr[k];
        v = vr[k] + (e >>> nk);
        nvr = (v > 4095) ? 4095 : (v < VMIN) ? VMIN : v;
        w = nwt + (1 << (10 - NW));
        nwt = (w > 1023) ? 1023 : w;
        ncn = (cn[k] == 63) ? 63 : cn[k] + 1;
      end
      q[36*k +: 36] = gs(nmu, nvr, nwt, ncn);
    end
  endfunction

  task automatic push(input int p, input logic [107:0] m);
    logic [107:0] q;
    logic f;
    @(negedge clk);
    in_valid = 1'b1; in_pixel = 8'(p); in_model = m;
    ref_px(p, m, q, f);
    exp_m[sent] = q; exp_f[sent] = f; t_in[sent] = cyc;
    sent++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compare each result; mismatch messages name the requirements involved
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (got >= sent) begin
        checks++; errors++;
        $display("FAIL R1: unexpected out_valid, got %0d expected %0d results", got + 1, sent);
      end else begin
        checks++;
        if (cyc - t_in[got] != LAT) begin
          errors++;
          $display("FAIL R1: item %0d latency %0d expected %0d", got, cyc - t_in[got], LAT);
        end
        checks++;
        if (out_model !== exp_m[got]) begin
          errors++;
          $display("FAIL R2 R3 R4 R5 R6 R7 R8: item %0d model %h expected %h",
                   got, out_model, exp_m[got]);
        end
        checks++;
        if (out_fg !== exp_f[got]) begin
          errors++;
          $display("FAIL R9: item %0d tag %0d expected %0d", got, out_fg, exp_f[got]);
        end
      end
      got++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1: watchdog expired, %0d of %0d results", got, sent);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    checks++;   // R10: reset holds output invalid
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R10: out_valid %0d expected 0 in reset", out_valid);
    end
    rst = 1'b0;
    idle(); idle();
    checks++;   // R10 and R1: no output without input after reset
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R10: out_valid %0d expected 0 after reset", out_valid);
    end

    // R3 R2: all three match, distinct fitness
    push(100, {gs(98, 300, 200, 3), gs(101, 40, 600, 10), gs(100, 900, 150, 1)});
    // R3: exact boundary 4*25^2 == 25*100 -> no match; 24 -> match
    push(125, {gs(0, 4, 100, 2), gs(0, 4, 100, 2), gs(100, 100, 500, 4)});
    push(124, {gs(0, 4, 100, 2), gs(0, 4, 100, 2), gs(100, 100, 500, 4)});
    // R2 R3: identical Gaussians all matching, tie picks index 0
    push(100, {gs(100, 50, 300, 5), gs(100, 50, 300, 5), gs(100, 50, 300, 5)});
    // R7 R8: identical Gaussians, no match, index 2 reseeded with S = 10
    push(200, {gs(100, 50, 300, 5), gs(100, 50, 300, 5), gs(100, 50, 300, 5)});
    // R8: counter sum saturates at 63
    push(250, {gs(10, 20, 400, 40), gs(20, 20, 300, 50), gs(30, 20, 100, 33)});
    // R8: zero counters give the full weight
    push(250, {gs(10, 20, 400, 0), gs(20, 20, 300, 0), gs(30, 20, 100, 0)});
    // R4: variance clamps at 4095
    push(127, {gs(255, 4, 10, 1), gs(255, 4, 10, 1), gs(0, 4095, 5, 1)});
    // R4: variance clamps at the lower limit
    push(50, {gs(200, 4, 10, 1), gs(200, 4, 10, 1), gs(50, 5, 20, 1)});
    // R5: weight and counter saturate
    push(60, {gs(200, 4, 10, 1), gs(200, 4, 10, 1), gs(60, 80, 1023, 63)});
    // R9: only a low-ranked Gaussian beyond the threshold matches -> foreground
    push(30, {gs(200, 100, 800, 9), gs(30, 4000, 100, 9), gs(220, 100, 700, 9)});
    idle();

    for (int i = 0; i < NRAND; i++) begin
      logic [107:0] m;
      int p, k;
      for (int g = 0; g < 3; g++)
        m[36*g +: 36] = gs($urandom % 256,
                           (($urandom % 4) == 0) ? $urandom % 4096 : 4 + $urandom % 400,
                           $urandom % 1024, $urandom % 64);
      if (($urandom % 10) < 7) begin
        k = $urandom % 3;
        p = int'(m[36*k +: 8]) + int'($urandom % 41) - 20;
        p = (p < 0) ? 0 : (p > 255) ? 255 : p;
      end else p = $urandom % 256;
      push(p, m);   // R4 R5 R6 R7 R9 under random traffic
      if (($urandom % 5) == 0) idle();
    end
    idle();
    repeat (LAT + 4) idle();
    checks++;   // R1: one result per accepted input
    if (got != sent) begin
      errors++; $display("FAIL R1: %0d results expected %0d", got, sent);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule